// File: doc/BRIEF.md
# Per-Core Memory Bandwidth Regulator

The regulator sits on the request path between each core's private cache and the shared memory interconnect. It caps the number of transactions that each regulation group of cores may send downstream during a repeating period. Refill requests caused by cache misses and dirty-line writebacks draw on two separate per-group budgets. When a group runs out of one budget, that class of request from every core in the group is held at the core side until the next period starts. The other class keeps flowing.

Each core presents a valid/ready pair and a class bit. The regulator forwards valid downstream and returns ready upstream, masking both for any core it is holding back. A small register port sets the period length, the two budgets of each group, the group that each core belongs to, and a per-group enable. The same port reads back a sticky per-group throttle flag and a count of cycles in which any request was held back.

Top module: `bwr_top`

## Requirements
- R1: After reset the registers read as follows: period (address 0) reads 15, the group enable mask (address 1) reads all ones, the core-to-group map (address 2) reads 0, the throttle flags (address 3) read 0, the stall count (address 4) reads 0, and every budget reads 4. The miss budget of group g is at address 8+2g and its writeback budget is at address 9+2g.
- R2: With its group enabled, a group never completes more miss handshakes within one period than its programmed miss budget. A budget of 0 blocks every miss request.
- R3: Writebacks (req_wb=1) are counted against the writeback budget only. Exhausting the miss budget does not hold back writebacks, and the reverse is also true.
- R4: Core c belongs to the group held in bits [c*GIDX_W +: GIDX_W] of the map register. All cores in one group draw on a single shared budget.
- R5: When several cores of one group present the same class in the same cycle and the remaining budget is smaller than their number, the cores with the lowest index are let through first.
- R6: A group whose bit in the enable mask is 0 passes all of its traffic and is never held back.
- R7: A budget is charged only when a valid/ready handshake completes. A request stalled by mem_ready=0 is not charged, and its mem_valid stays high.
- R8: The period counter wraps every P+1 cycles, where P is the period register value. The wrap cycle reloads every budget, and a handshake in the wrap cycle is charged to the new period. Writing the period register restarts the counter and reloads all budgets.
- R9: A group's throttle flag (bit g of address 3) is set when a request in that group is held back, and it stays set. The stall count at address 4 counts cycles in which any request is held back and saturates at its maximum. Any write to address 3 clears both the flags and the count.
- R10: For every core, mem_valid = req_valid and not held back, and req_ready = mem_ready and not held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Request valid from each core |
| req_wb | input | NUM_CORES | Request class per core: 1 = writeback, 0 = miss refill |
| req_ready | output | NUM_CORES | Ready returned to each core |
| mem_valid | output | NUM_CORES | Gated request valid toward the interconnect |
| mem_ready | input | NUM_CORES | Ready from the interconnect per core |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for cfg_addr |

## Verification
The bench drives several cores into one group in the same cycle with a small budget. A design that checks each core against the remaining budget on its own would overshoot the budget, and one with the wrong priority would hand grants to the wrong cores. It mixes classes inside a group to catch a shared or swapped counter, in which case a starved miss budget would also stop writebacks. It holds mem_ready low on a pending request to catch double charging, which would show up as fewer grants once ready returns. It also places a grant exactly on the wrap cycle, where a design that lets the old period win would grant again in the following cycle.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_PERIOD      = 5'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE      = 5'd1;
  localparam logic [ADDR_W-1:0] A_GMAP        = 5'd2;
  localparam logic [ADDR_W-1:0] A_THROT       = 5'd3;
  localparam logic [ADDR_W-1:0] A_STALL       = 5'd4;
  localparam logic [ADDR_W-1:0] A_BUDGET_BASE = 5'd8;

  // budget register address for a group and class (0 = miss, 1 = writeback)
  function automatic logic [ADDR_W-1:0] budget_addr(input int grp, input logic is_wb);
    return A_BUDGET_BASE + ADDR_W'(2 * grp) + ADDR_W'(is_wb);
  endfunction
endpackage

// File: rtl/bwr_period_timer.sv
module bwr_period_timer #(
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_len,
  input  logic                restart,
  output logic                wrap_o
);
  logic [PERIOD_W-1:0] cnt;

  assign wrap_o = (cnt == period_len);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || wrap_o) cnt <= '0;
    else                        cnt <= cnt + PERIOD_W'(1);
  end
endmodule

// File: rtl/bwr_budget_ctr.sv
module bwr_budget_ctr #(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned CHG_W      = 3,
  parameter int unsigned DEF_BUDGET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             enable,
  input  logic [CNT_W-1:0] budget,
  input  logic [CHG_W-1:0] charge,
  output logic [CNT_W-1:0] avail_o,
  output logic [CNT_W-1:0] left_o
);
  logic [CNT_W-1:0] left;

  function automatic logic [CNT_W-1:0] after_charge(input logic [CNT_W-1:0] room,
                                                    input logic [CHG_W-1:0] n,
                                                    input logic on);
    if (!on) return room;
    if (CNT_W'(n) >= room) return '0;
    return room - CNT_W'(n);
  endfunction

  // in a reload cycle the new period's budget is what this cycle spends
  assign avail_o = reload ? budget : left;
  assign left_o  = left;

  always_ff @(posedge clk) begin
    if (!rst_n) left <= CNT_W'(DEF_BUDGET);
    else        left <= after_charge(avail_o, charge, enable);
  end
endmodule

// File: rtl/bwr_top.sv
module bwr_top
  import bwr_pkg::*;
#(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PERIOD_W   = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DEF_PERIOD = 15,
  parameter int unsigned DEF_BUDGET = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] req_valid,
  input  logic [NUM_CORES-1:0] req_wb,
  output logic [NUM_CORES-1:0] req_ready,
  output logic [NUM_CORES-1:0] mem_valid,
  input  logic [NUM_CORES-1:0] mem_ready,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata
);
  localparam int unsigned GIDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int unsigned CHG_W  = $clog2(NUM_CORES + 1);
  localparam int unsigned MAP_W  = NUM_CORES * GIDX_W;

  // configuration and monitor state
  logic [PERIOD_W-1:0]   period_len;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [MAP_W-1:0]      core_map;
  logic [CNT_W-1:0]      miss_bud [NUM_GROUPS];
  logic [CNT_W-1:0]      wb_bud   [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] thr_flag;
  logic [DATA_W-1:0]     stall_cnt;

  // named internal events
  logic                  restart, clear_mon, wrap, reload;
  logic [GIDX_W-1:0]     core_grp   [NUM_CORES];
  logic [CNT_W-1:0]      miss_avail [NUM_GROUPS];
  logic [CNT_W-1:0]      wb_avail   [NUM_GROUPS];
  logic [CNT_W-1:0]      miss_left  [NUM_GROUPS];
  logic [CNT_W-1:0]      wb_left    [NUM_GROUPS];
  logic [CHG_W-1:0]      miss_chg   [NUM_GROUPS];
  logic [CHG_W-1:0]      wb_chg     [NUM_GROUPS];
  logic [NUM_CORES-1:0]  allow, hs, blocked;
  logic [NUM_GROUPS-1:0] thr_set;

  // requests of lower-index cores in the same group and class as core c
  function automatic logic [CHG_W-1:0] count_ahead(input logic [NUM_CORES-1:0] v,
                                                   input logic [NUM_CORES-1:0] wb,
                                                   input logic [MAP_W-1:0] map,
                                                   input int c);
    logic [CHG_W-1:0] n;
    n = '0;
    for (int j = 0; j < NUM_CORES; j++)
      if (j < c && v[j] && wb[j] == wb[c] &&
          map[j*GIDX_W +: GIDX_W] == map[c*GIDX_W +: GIDX_W])
        n = n + CHG_W'(1);
    return n;
  endfunction

  // events in a vector that fall on group g and class cls
  function automatic logic [CHG_W-1:0] count_class(input logic [NUM_CORES-1:0] ev,
                                                   input logic [NUM_CORES-1:0] wb,
                                                   input logic [MAP_W-1:0] map,
                                                   input logic cls,
                                                   input int g);
    logic [CHG_W-1:0] n;
    n = '0;
    for (int j = 0; j < NUM_CORES; j++)
      if (ev[j] && wb[j] == cls && map[j*GIDX_W +: GIDX_W] == GIDX_W'(g))
        n = n + CHG_W'(1);
    return n;
  endfunction

  assign restart   = cfg_we && (cfg_addr == A_PERIOD);
  assign clear_mon = cfg_we && (cfg_addr == A_THROT);
  assign reload    = wrap | restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_len <= PERIOD_W'(DEF_PERIOD);
      grp_en     <= '1;
      core_map   <= '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        miss_bud[g] <= CNT_W'(DEF_BUDGET);
        wb_bud[g]   <= CNT_W'(DEF_BUDGET);
      end
    end else if (cfg_we) begin
      if (cfg_addr == A_PERIOD) period_len <= cfg_wdata[PERIOD_W-1:0];
      if (cfg_addr == A_ENABLE) grp_en     <= cfg_wdata[NUM_GROUPS-1:0];
      if (cfg_addr == A_GMAP)   core_map   <= cfg_wdata[MAP_W-1:0];
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (cfg_addr == budget_addr(g, 1'b0)) miss_bud[g] <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == budget_addr(g, 1'b1)) wb_bud[g]   <= cfg_wdata[CNT_W-1:0];
      end
    end
  end

  bwr_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_len(period_len), .restart(restart), .wrap_o(wrap)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    bwr_budget_ctr #(.CNT_W(CNT_W), .CHG_W(CHG_W), .DEF_BUDGET(DEF_BUDGET)) u_miss (
      .clk(clk), .rst_n(rst_n), .reload(reload), .enable(grp_en[g]),
      .budget(miss_bud[g]), .charge(miss_chg[g]),
      .avail_o(miss_avail[g]), .left_o(miss_left[g])
    );
    bwr_budget_ctr #(.CNT_W(CNT_W), .CHG_W(CHG_W), .DEF_BUDGET(DEF_BUDGET)) u_wb (
      .clk(clk), .rst_n(rst_n), .reload(reload), .enable(grp_en[g]),
      .budget(wb_bud[g]), .charge(wb_chg[g]),
      .avail_o(wb_avail[g]), .left_o(wb_left[g])
    );
    assign miss_chg[g] = count_class(hs, req_wb, core_map, 1'b0, g);
    assign wb_chg[g]   = count_class(hs, req_wb, core_map, 1'b1, g);
    assign thr_set[g]  = (count_class(blocked, req_wb, core_map, 1'b0, g) != '0) ||
                         (count_class(blocked, req_wb, core_map, 1'b1, g) != '0);
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [CNT_W-1:0] room;
    assign core_grp[c]  = core_map[c*GIDX_W +: GIDX_W];
    assign room         = req_wb[c] ? wb_avail[core_grp[c]] : miss_avail[core_grp[c]];
    assign allow[c]     = !grp_en[core_grp[c]] ||
                          (CNT_W'(count_ahead(req_valid, req_wb, core_map, c)) < room);
    assign hs[c]        = req_valid[c] & mem_ready[c] & allow[c];
    assign blocked[c]   = req_valid[c] & ~allow[c];
    assign mem_valid[c] = req_valid[c] & allow[c];
    assign req_ready[c] = mem_ready[c] & allow[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_mon) begin
      thr_flag  <= '0;
      stall_cnt <= '0;
    end else begin
      thr_flag <= thr_flag | thr_set;
      if (|blocked && stall_cnt != '1) stall_cnt <= stall_cnt + DATA_W'(1);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_PERIOD) cfg_rdata = DATA_W'(period_len);
    if (cfg_addr == A_ENABLE) cfg_rdata = DATA_W'(grp_en);
    if (cfg_addr == A_GMAP)   cfg_rdata = DATA_W'(core_map);
    if (cfg_addr == A_THROT)  cfg_rdata = DATA_W'(thr_flag);
    if (cfg_addr == A_STALL)  cfg_rdata = stall_cnt;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (cfg_addr == budget_addr(g, 1'b0)) cfg_rdata = DATA_W'(miss_bud[g]);
      if (cfg_addr == budget_addr(g, 1'b1)) cfg_rdata = DATA_W'(wb_bud[g]);
    end
  end
endmodule

// File: rtl/bwr_checker.sv
module bwr_checker #(
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned CHG_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned GIDX_W     = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_CORES-1:0]  req_valid,
  input logic [NUM_CORES-1:0]  req_ready,
  input logic [NUM_CORES-1:0]  mem_valid,
  input logic [NUM_CORES-1:0]  mem_ready,
  input logic [NUM_CORES-1:0]  blocked,
  input logic [NUM_GROUPS-1:0] grp_en,
  input logic [GIDX_W-1:0]     core_grp   [NUM_CORES],
  input logic                  reload,
  input logic                  clear_mon,
  input logic [DATA_W-1:0]     stall_cnt,
  input logic [CNT_W-1:0]      miss_bud   [NUM_GROUPS],
  input logic [CNT_W-1:0]      miss_avail [NUM_GROUPS],
  input logic [CNT_W-1:0]      miss_left  [NUM_GROUPS],
  input logic [CHG_W-1:0]      miss_chg   [NUM_GROUPS],
  input logic [CNT_W-1:0]      wb_avail   [NUM_GROUPS],
  input logic [CHG_W-1:0]      wb_chg     [NUM_GROUPS]
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk_grp
    assert_miss_within_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grp_en[g] |-> (CNT_W'(miss_chg[g]) <= miss_avail[g]));
    assert_wb_within_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grp_en[g] |-> (CNT_W'(wb_chg[g]) <= wb_avail[g]));
    assert_reload_refills_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && grp_en[g] && miss_chg[g] == '0) |=> (miss_left[g] == $past(miss_bud[g])));
    assert_idle_not_charged_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && miss_chg[g] == '0) |=> $stable(miss_left[g]));
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk_core
    assert_disabled_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      blocked[c] |-> grp_en[core_grp[c]]);
    assert_valid_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid[c] |-> req_valid[c]);
    assert_ready_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[c] |-> mem_ready[c]);
  end

  assert_stall_count_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_mon |=> (stall_cnt >= $past(stall_cnt)));
endmodule

bind bwr_top bwr_checker #(
  .NUM_CORES(NUM_CORES), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W),
  .CHG_W(CHG_W), .DATA_W(DATA_W), .GIDX_W(GIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .blocked(blocked), .grp_en(grp_en),
  .core_grp(core_grp), .reload(reload), .clear_mon(clear_mon), .stall_cnt(stall_cnt),
  .miss_bud(miss_bud), .miss_avail(miss_avail), .miss_left(miss_left),
  .miss_chg(miss_chg), .wb_avail(wb_avail), .wb_chg(wb_chg)
);

// File: tb/bwr_top_tb.sv
module bwr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n;
  logic [NC-1:0] req_valid, req_wb, req_ready, mem_valid, mem_ready;
  logic          cfg_we;
  logic [4:0]    cfg_addr;
  logic [15:0]   cfg_wdata, cfg_rdata;

  bwr_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wb(req_wb),
    .req_ready(req_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int   checks = 0;
  int   errors = 0;
  logic done   = 1'b0;

  typedef struct packed {
    logic [7:0] mb0, wb0, mb1, wb1, per;
    logic [3:0] map;
    logic [1:0] en;
    logic [3:0] wbsel;
    logic [7:0] e0, e1, e2, e3;
  } vec_t;

  // budgets, period, core map, enables, class per core -> grants per core in P cycles
  localparam vec_t VECS [6] = '{
    '{8'd5, 8'd4, 8'd4, 8'd4, 8'd6, 4'b0000, 2'b01, 4'b0000, 8'd2, 8'd1, 8'd1, 8'd1},
    '{8'd3, 8'd4, 8'd4, 8'd4, 8'd6, 4'b0000, 2'b01, 4'b1010, 8'd2, 8'd2, 8'd1, 8'd2},
    '{8'd1, 8'd4, 8'd4, 8'd4, 8'd5, 4'b1100, 2'b11, 4'b0000, 8'd1, 8'd0, 8'd2, 8'd2},
    '{8'd0, 8'd4, 8'd0, 8'd4, 8'd5, 4'b1100, 2'b01, 4'b0000, 8'd0, 8'd0, 8'd5, 8'd5},
    '{8'd0, 8'd3, 8'd4, 8'd4, 8'd4, 4'b0000, 2'b01, 4'b0001, 8'd3, 8'd0, 8'd0, 8'd0},
    '{8'd0, 8'd4, 8'd3, 8'd4, 8'd4, 4'b0101, 2'b10, 4'b0000, 8'd2, 8'd4, 8'd1, 8'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    int exp_rdy [6];
    rst_n = 1'b0; req_valid = '0; req_wb = '0; mem_ready = '1;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(5'd0, rv);  chk("R1 period", rv, 15);
    rd(5'd1, rv);  chk("R1 enable", rv, 3);
    rd(5'd2, rv);  chk("R1 map", rv, 0);
    rd(5'd3, rv);  chk("R1 flags", rv, 0);
    rd(5'd4, rv);  chk("R1 stall", rv, 0);
    rd(5'd8, rv);  chk("R1 miss budget g0", rv, 4);
    rd(5'd11, rv); chk("R1 wb budget g1", rv, 4);
    @(negedge clk);

    // vector table: R2 R3 R4 R5 R6 R8 (period write restarts and reloads)
    for (int v = 0; v < 6; v++) begin
      vec_t t;
      int got [NC];
      t = VECS[v];
      for (int c = 0; c < NC; c++) got[c] = 0;
      wr(5'd8, 16'(t.mb0)); wr(5'd9, 16'(t.wb0));
      wr(5'd10, 16'(t.mb1)); wr(5'd11, 16'(t.wb1));
      wr(5'd2, 16'(t.map)); wr(5'd1, 16'(t.en));
      wr(5'd0, 16'(t.per));
      req_wb = t.wbsel; req_valid = '1;
      for (int k = 0; k < int'(t.per); k++) begin
        #1;
        for (int c = 0; c < NC; c++) if (req_ready[c]) got[c]++;
        @(negedge clk);
      end
      req_valid = '0;
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d core 0", v), got[0], int'(t.e0));
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d core 1", v), got[1], int'(t.e1));
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d core 2", v), got[2], int'(t.e2));
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d core 3", v), got[3], int'(t.e3));
    end

    // R8: wrap cycle grants from the new budget; R9 monitors; R10 gating
    wr(5'd3, 16'd0);
    wr(5'd2, 16'd0); wr(5'd1, 16'd1); wr(5'd8, 16'd1);
    wr(5'd0, 16'd4);
    exp_rdy = '{1, 0, 0, 0, 1, 0};
    req_wb = '0; req_valid = 4'b0001;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk($sformatf("R8 ready cycle %0d", k), int'(req_ready[0]), exp_rdy[k]);
      chk($sformatf("R10 mem_valid cycle %0d", k), int'(mem_valid[0]), exp_rdy[k]);
      @(negedge clk);
    end
    req_valid = '0;
    rd(5'd3, rv); chk("R9 throttle flags", rv, 1);
    rd(5'd4, rv); chk("R9 stall count", rv, 4);
    @(negedge clk);
    wr(5'd3, 16'd0);
    rd(5'd4, rv); chk("R9 stall count cleared", rv, 0);
    @(negedge clk);

    // R7: stalled request keeps mem_valid and is not charged
    wr(5'd8, 16'd2); wr(5'd0, 16'd20);
    req_valid = 4'b0001; mem_ready = 4'b1110;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R7 stalled ready", int'(req_ready[0]), 0);
      chk("R7 stalled mem_valid", int'(mem_valid[0]), 1);
      @(negedge clk);
    end
    mem_ready = '1;
    exp_rdy = '{1, 1, 0, 0, 0, 0};
    for (int k = 0; k < 4; k++) begin
      #1;
      chk($sformatf("R7 grant after stall cycle %0d", k), int'(req_ready[0]), exp_rdy[k]);
      @(negedge clk);
    end
    req_valid = '0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule